// File: doc/BRIEF.md
# Auto-Reload Interval Timer

This block is a countdown timer that raises a periodic interrupt. Software programs a start value, one byte at a time, into three write-only byte registers: an upper, a middle and a low byte that together form a 24-bit value. It then writes a control register to start or stop the timer. While the timer runs, the counter drops by one on every clock. When the counter is at zero, the next clock sets a sticky rollover flag and reloads the start value, and counting carries on without software. The interrupt period is therefore fixed at start value plus one clocks, however late software handles the interrupt.

Software clears the interrupt by writing the start bit again. This clears the flag and restarts the count from the start value, and the timer keeps running. A control read returns the running state and the rollover flag. The rollover flag also drives the interrupt output. Bus decoding and interrupt prioritisation are done outside this block.

Top module: `interval_timer`

## Requirements
- R1: While reset is asserted and after its release, the enable and the rollover flag are 0, so `ctrl_rd_data` reads 0 and `irq_out` is 0.
- R2: A write with `wr_idx` 0 loads bits 23:16 of the start value, `wr_idx` 1 loads bits 15:8 and `wr_idx` 2 loads bits 7:0. The other bytes keep their values.
- R3: A write with `wr_idx` 3 addresses the control register. The write is registered into a trigger that lasts one cycle, so the control write sampled at clock edge N acts at edge N+1.
- R4: A trigger with data bit 0 set and bit 1 clear loads the counter from the start value, sets the enable and clears the rollover flag. This applies whether the timer is stopped or running.
- R5: While enabled and not triggered, a nonzero counter decrements by one per clock. With start value S, the rollover flag first becomes visible S+1 edges after the load edge. With S = 0 it becomes visible one edge after the load edge.
- R6: At an edge where the timer is enabled and the counter is zero, the flag is set, the counter reloads from the start value and the enable stays 1.
- R7: The rollover flag stays set until a start trigger or reset clears it. A stop does not clear it.
- R8: A trigger with data bit 1 set clears the enable. While the timer is stopped, the counter holds and no rollover occurs.
- R9: A trigger with bits 0 and 1 both set stops the timer; the stop takes priority.
- R10: `ctrl_rd_data` bit 0 is the enable and bit 1 is the rollover flag. Bits 7:2 are 0, and `irq_out` equals the rollover flag.
- R11: A start-value write made while the timer runs does not alter the count in progress. The new value is used at the next reload or start.
- R12: A control write with bits 0 and 1 both clear changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_idx | input | 2 | Register index: 0 upper, 1 middle, 2 low, 3 control |
| wr_data | input | 8 | Write data byte |
| ctrl_rd_data | output | 8 | Control read value: bit 0 enable, bit 1 rollover flag |
| irq_out | output | 1 | Rollover interrupt, active high |

## Verification
A control write sampled at edge N moves the enable and the flag at edge N+1. The bench therefore expects no change on the first falling edge after the write and the new state on the second. A start-value write is stored at its own edge but is only seen at the next reload. Once the timer is loaded, the first rollover flag is due exactly S+1 edges later. The bench counts falling edges until the flag rises and compares the count with S+1. A behavioural model, updated at each rising edge, is compared with the outputs on every falling edge, where all of them are settled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // control word bit positions (software visible)
  localparam int CTRL_START_BIT = 0;
  localparam int CTRL_STOP_BIT  = 1;
  // status read bit positions
  localparam int STAT_EN_BIT    = 0;
  localparam int STAT_ROLL_BIT  = 1;

  typedef struct packed {
    logic stop;
    logic start;
  } tmr_cmd_t;

  // byte lane reached by a register index: index 0 is the most significant lane
  function automatic int lane_of_idx(input int idx, input int nbytes);
    return nbytes - 1 - idx;
  endfunction
endpackage

// File: rtl/tmr_start_regs.sv
module tmr_start_regs #(
  parameter int NBYTES  = 3,
  parameter int BYTE_W  = 8,
  parameter int IDX_W   = 2,
  localparam int VAL_W  = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [VAL_W-1:0]  start_val
);
  import tmr_pkg::*;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    localparam int LANE_IDX = lane_of_idx(g, NBYTES);
    logic [BYTE_W-1:0] lane_q;
    logic              lane_hit;
    assign lane_hit = wr_en && (wr_idx == IDX_W'(LANE_IDX));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane_q <= '0;
      else if (lane_hit) lane_q <= wr_data;
    end
    assign start_val[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/tmr_ctrl_trigger.sv
module tmr_ctrl_trigger #(
  parameter int BYTE_W   = 8,
  parameter int IDX_W    = 2,
  parameter int CTRL_IDX = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              trig,
  output tmr_pkg::tmr_cmd_t cmd
);
  import tmr_pkg::*;

  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_idx == IDX_W'(CTRL_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= 1'b0;
      cmd  <= '0;
    end else begin
      trig <= ctrl_hit;
      if (ctrl_hit) begin
        cmd.start <= wr_data[CTRL_START_BIT];
        cmd.stop  <= wr_data[CTRL_STOP_BIT];
      end
    end
  end
endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown #(
  parameter int VAL_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  tmr_pkg::tmr_cmd_t cmd,
  input  logic [VAL_W-1:0]  start_val,
  output logic [VAL_W-1:0]  count,
  output logic              enable,
  output logic              roll_flag,
  output logic              count_zero,
  output logic              roll_event,
  output logic              load_event,
  output logic              stop_event
);
  // one step of a running counter: reload on zero, else decrement
  function automatic logic [VAL_W-1:0] step(input logic [VAL_W-1:0] cur,
                                            input logic [VAL_W-1:0] rel);
    return (cur == '0) ? rel : cur - VAL_W'(1);
  endfunction

  assign count_zero = (count == '0);
  assign stop_event = trig && cmd.stop;
  assign load_event = trig && cmd.start && !cmd.stop;
  assign roll_event = !trig && enable && count_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      enable    <= 1'b0;
      roll_flag <= 1'b0;
    end else if (stop_event) begin
      enable <= 1'b0;
    end else if (load_event) begin
      count     <= start_val;
      enable    <= 1'b1;
      roll_flag <= 1'b0;
    end else if (!trig && enable) begin
      count <= step(count, start_val);
      if (roll_event) roll_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int NBYTES = 3,
  parameter int BYTE_W = 8,
  localparam int COUNT_W  = NBYTES * BYTE_W,
  localparam int CTRL_IDX = NBYTES,
  localparam int IDX_W    = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ctrl_rd_data,
  output logic              irq_out
);
  import tmr_pkg::*;

  logic [COUNT_W-1:0] start_val;
  logic [COUNT_W-1:0] count;
  logic               trig;
  tmr_cmd_t           cmd;
  logic               enable;
  logic               roll_flag;
  logic               count_zero;
  logic               roll_event;
  logic               load_event;
  logic               stop_event;

  tmr_start_regs #(.NBYTES(NBYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_start (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .start_val(start_val)
  );

  tmr_ctrl_trigger #(.BYTE_W(BYTE_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_trig (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .trig(trig), .cmd(cmd)
  );

  tmr_countdown #(.VAL_W(COUNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .trig(trig), .cmd(cmd), .start_val(start_val),
    .count(count), .enable(enable), .roll_flag(roll_flag),
    .count_zero(count_zero), .roll_event(roll_event),
    .load_event(load_event), .stop_event(stop_event)
  );

  always_comb begin
    ctrl_rd_data                = '0;
    ctrl_rd_data[STAT_EN_BIT]   = enable;
    ctrl_rd_data[STAT_ROLL_BIT] = roll_flag;
  end
  assign irq_out = roll_flag;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int COUNT_W = 24,
  parameter int BYTE_W  = 8,
  parameter int IDX_W   = 2,
  parameter int CTRL_IDX = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [BYTE_W-1:0]  ctrl_rd_data,
  input logic               irq_out,
  input logic               trig,
  input logic               enable,
  input logic               roll_flag,
  input logic [COUNT_W-1:0] count,
  input logic               count_zero,
  input logic               load_event,
  input logic               stop_event
);
  AST_READ_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd_data[BYTE_W-1:2] == '0); // R10
  AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ctrl_rd_data[1]); // R10
  AST_TRIG_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(wr_en && wr_idx == IDX_W'(CTRL_IDX))); // R3
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    load_event |=> enable && !roll_flag); // R4
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_event |=> !enable); // R9
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !trig && !count_zero |=> count == $past(count) - COUNT_W'(1)); // R5
  AST_ROLL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !trig && count_zero |=> roll_flag && enable); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    roll_flag && !load_event |=> roll_flag); // R7
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !trig |=> $stable(count) && $stable(roll_flag)); // R8
endmodule

bind interval_timer interval_timer_chk #(
  .COUNT_W(COUNT_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .ctrl_rd_data(ctrl_rd_data), .irq_out(irq_out), .trig(trig),
  .enable(enable), .roll_flag(roll_flag), .count(count),
  .count_zero(count_zero), .load_event(load_event), .stop_event(stop_event)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl_rd_data;
  logic       irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .ctrl_rd_data(ctrl_rd_data), .irq_out(irq_out)
  );

  // behavioural model state
  int m_start, m_cnt;
  bit m_en, m_flag, m_trig, m_tstart, m_tstop;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_cnt = 0; m_en = 0; m_flag = 0; m_trig = 0;
      m_tstart = 0; m_tstop = 0;
    end else begin
      if (m_trig) begin
        if (m_tstop) m_en = 0;
        else if (m_tstart) begin m_cnt = m_start; m_en = 1; m_flag = 0; end
      end else if (m_en) begin
        if (m_cnt == 0) begin m_cnt = m_start; m_flag = 1; end
        else m_cnt = m_cnt - 1;
      end
      m_trig = wr_en && wr_idx == 2'd3;
      if (m_trig) begin m_tstart = wr_data[0]; m_tstop = wr_data[1]; end
      if (wr_en && wr_idx != 2'd3) begin
        int sh;
        sh = (2 - int'(wr_idx)) * 8;
        m_start = (m_start & ~(255 << sh)) | (int'(wr_data) << sh);
      end
    end
  end

  // per-cycle comparison with the model, R5 R6 R10 R11
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(ctrl_rd_data == {6'b0, m_flag, m_en}, "R5/R6/R11 model read",
            int'(ctrl_rd_data), int'({6'b0, m_flag, m_en}));
      check(irq_out == ctrl_rd_data[1], "R10 irq vs read", int'(irq_out),
            int'(ctrl_rd_data[1]));
    end
  end

  task automatic write_reg(input int idx, input int data);
    wr_en = 1; wr_idx = 2'(idx); wr_data = 8'(data);
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_start(input int v);
    write_reg(0, (v >> 16) & 255);
    write_reg(1, (v >> 8) & 255);
    write_reg(2, v & 255);
  endtask

  // counts falling edges until the flag is seen
  task automatic wait_flag(output int n);
    n = 0;
    while (!ctrl_rd_data[1] && n < 100000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int n;
    @(negedge clk);
    check(ctrl_rd_data == 8'h00, "R1 read during reset", int'(ctrl_rd_data), 0);
    check(irq_out == 1'b0, "R1 irq during reset", int'(irq_out), 0);
    idle(2);
    rst_n = 1;
    idle(2);
    check(ctrl_rd_data == 8'h00, "R1 read after reset", int'(ctrl_rd_data), 0);

    // R2: byte lanes; 0x000102 gives a 259-edge first period
    set_start(32'h00_01_02);
    write_reg(3, 0);                  // R12: no bits set
    idle(3);
    check(ctrl_rd_data == 8'h00, "R12 empty control write", int'(ctrl_rd_data), 0);

    // R3: acts one edge after the write edge
    wr_en = 1; wr_idx = 2'd3; wr_data = 8'h01;
    @(posedge clk); @(negedge clk);
    wr_en = 0;
    check(ctrl_rd_data[0] == 1'b0, "R3 not yet enabled", int'(ctrl_rd_data[0]), 0);
    @(negedge clk);
    check(ctrl_rd_data[0] == 1'b1, "R3 enabled next edge", int'(ctrl_rd_data[0]), 1);
    wait_flag(n);
    check(n == 259, "R2 R5 first period", n, 259);
    check(ctrl_rd_data[0] == 1'b1, "R6 keeps running", int'(ctrl_rd_data[0]), 1);
    idle(300);
    check(ctrl_rd_data == 8'h03, "R7 flag sticky", int'(ctrl_rd_data), 3);

    // R4: restart clears the flag and keeps running
    write_reg(3, 1);
    @(negedge clk);
    check(ctrl_rd_data == 8'h01, "R4 restart clears flag", int'(ctrl_rd_data), 1);

    // R2: change middle byte only -> value 2
    write_reg(1, 0);
    write_reg(3, 1);
    @(negedge clk);
    wait_flag(n);
    check(n == 3, "R2 middle byte only", n, 3);

    // R11: start value 3, new low byte written right after the load
    write_reg(2, 3);
    write_reg(3, 1);
    write_reg(2, 9);
    wait_flag(n);
    check(n == 4, "R11 running count unchanged", n, 4);
    // R8: stop keeps flag (R7), holds
    write_reg(3, 2);
    @(negedge clk);
    check(ctrl_rd_data == 8'h02, "R8 stopped, R7 flag kept", int'(ctrl_rd_data), 2);
    idle(20);
    check(ctrl_rd_data == 8'h02, "R8 holds while stopped", int'(ctrl_rd_data), 2);
    // R11: next start uses 9
    write_reg(3, 1);
    @(negedge clk);
    wait_flag(n);
    check(n == 10, "R11 new value at start", n, 10);

    // R8: no rollover while stopped
    write_reg(3, 1);
    write_reg(3, 2);
    @(negedge clk);
    idle(40);
    check(ctrl_rd_data == 8'h00, "R8 no rollover when stopped", int'(ctrl_rd_data), 0);

    // R9: both bits -> stop
    write_reg(3, 1);
    @(negedge clk);
    write_reg(3, 3);
    @(negedge clk);
    check(ctrl_rd_data[0] == 1'b0, "R9 stop wins", int'(ctrl_rd_data[0]), 0);

    // R5 boundary: start value 0 rolls on the edge after the load
    set_start(0);
    write_reg(3, 1);
    @(negedge clk);
    check(ctrl_rd_data == 8'h01, "R5 zero start loaded", int'(ctrl_rd_data), 1);
    @(negedge clk);
    check(ctrl_rd_data == 8'h03, "R5 zero start rolls", int'(ctrl_rd_data), 3);

    // R1: reset in the middle of a run
    rst_n = 0;
    @(negedge clk);
    check(ctrl_rd_data == 8'h00 && irq_out == 1'b0, "R1 reset mid-run",
          int'(ctrl_rd_data), 0);
    idle(2);
    rst_n = 1;
    idle(5);
    check(ctrl_rd_data == 8'h00, "R1 stays idle", int'(ctrl_rd_data), 0);
    summary();
  end
endmodule